// File: doc/BRIEF.md
# Peripheral Clock Stop Controller

This block holds a bank of per-module clock gate controls behind a small register bus. A stop register carries one bit per peripheral module. A 1 in a bit shuts that module's clock off and a 0 lets it run. The block drives one clock enable per module straight from the stop register, so a module's enable follows its stop bit in the cycle after the write.

A read-only status register uses the same bit positions. Each status bit shows whether the matching module has really started or stopped. Every status bit copies its stop bit only after a fixed settle delay of `SETTLE_CYCLES` reference clock cycles, and each bit keeps its own delay counter. Software writes a stop bit and then polls the status bit, with a bounded retry count, until the change shows. The settle delay therefore has to stay well below that retry bound, and the block refuses parameter values that are not.

The register width (`NUM_MODS`, which may be 8, 16 or 32) and the settle delay are parameters. The stop register sits at byte offset 0x0 and the status register at 0x4.

Top module: `mod_clk_stop_ctrl`

## Requirements
- R1: A write cycle (bus_sel=1, bus_wr=1) to offset 0x0 loads bus_wdata into the stop register. From the following cycle, mod_clk_en[i] equals the inverse of stop bit i, and a read of offset 0x0 returns the written value.
- R2: After reset, every stop bit and every status bit reads 1 and every mod_clk_en bit is 0.
- R3: A read of offset 0x4 returns the status register, using the same bit positions as the stop register. A status bit takes a new stop value exactly SETTLE_CYCLES rising edges after the edge that wrote it, and keeps its old value before that.
- R4: When a stop bit is set to 1, the module's enable drops in the next cycle. The status bit keeps reading 0 for the whole settle wait.
- R5: Each bit is timed on its own. A write that leaves a bit's value unchanged does not restart that bit's pending delay.
- R6: If a stop bit is written back to its status value before the delay ends, the status bit never changes. A later change starts a full new delay.
- R7: Writes to offset 0x4 or to any unmapped offset change neither register nor any enable. Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_MODS | Write data |
| bus_rdata | output | NUM_MODS | Read data for bus_addr (combinational) |
| mod_clk_en | output | NUM_MODS | Per-module clock enable, 1 = clock runs |

## Verification
The assertions assume that bus_sel, bus_wr, bus_addr and bus_wdata hold known values at every rising edge after reset. They also assume that a write lasts exactly one cycle, so that "the cycle after the write" is well defined for the stop register and the change masks. The bench drives every bus signal from tasks on the falling clock edge and holds each write strobe for a single cycle. Between accesses it returns bus_sel and bus_wr to 0. It samples reads half a cycle after the edge they follow, so every status check lands on a known count of edges from its write.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Byte offsets decoded by the register interface
  localparam int STOP_OFS = 0;
  localparam int STAT_OFS = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STOP = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  // A status bit is due to copy its stop bit when it differs, the count
  // has reached its last value and no fresh change restarts the wait.
  function automatic logic settle_due(input logic mismatch,
                                      input logic at_last,
                                      input logic restart);
    return mismatch && at_last && !restart;
  endfunction

endpackage

// File: rtl/mcs_regif.sv
module mcs_regif
  import mcs_pkg::*;
#(
  parameter int NUM_MODS = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_MODS-1:0] bus_wdata,
  output logic [NUM_MODS-1:0] stop_q,
  output logic [NUM_MODS-1:0] chg_mask,
  output reg_sel_e            reg_sel
);

  localparam logic [ADDR_W-1:0] STOP_A = ADDR_W'(STOP_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == STOP_A) return SEL_STOP;
    if (a == STAT_A) return SEL_STAT;
    return SEL_NONE;
  endfunction

  // Bits whose value a write actually flips
  function automatic logic [NUM_MODS-1:0] flip_mask(input logic hit,
                                                    input logic [NUM_MODS-1:0] nxt,
                                                    input logic [NUM_MODS-1:0] cur);
    return hit ? (nxt ^ cur) : '0;
  endfunction

  logic stop_wr;
  logic stat_wr;

  assign reg_sel  = decode(bus_addr);
  assign stop_wr  = bus_sel && bus_wr && (reg_sel == SEL_STOP);
  assign stat_wr  = bus_sel && bus_wr && (reg_sel != SEL_STOP);
  assign chg_mask = flip_mask(stop_wr, bus_wdata, stop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= '1;
    else if (stop_wr) stop_q <= bus_wdata;
  end

  AST_STOP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (stop_q == $past(bus_wdata))); // R1
  AST_OTHER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> $stable(stop_q)); // R7

endmodule

// File: rtl/mcs_settle_bit.sv
module mcs_settle_bit
  import mcs_pkg::*;
#(
  parameter int SETTLE_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic chg_i,
  output logic stat_o
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST_C = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          mismatch;
  logic          at_last;
  logic          due;

  assign mismatch = (stop_i != stat_o);
  assign at_last  = (cnt_q == LAST_C);
  assign due      = settle_due(mismatch, at_last, chg_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_o <= 1'b1;
    end else if (chg_i) begin
      cnt_q <= '0;
    end else if (due) begin
      cnt_q  <= '0;
      stat_o <= stop_i;
    end else if (mismatch) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  AST_STAT_COPIES_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> (stat_o == $past(stop_i))); // R3
  AST_STAT_HOLDS_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !due |=> $stable(stat_o)); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C); // R5
  AST_CHANGE_DELAYS: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> $stable(stat_o)); // R5

endmodule

// File: rtl/mod_clk_stop_ctrl.sv
module mod_clk_stop_ctrl
  import mcs_pkg::*;
#(
  parameter int NUM_MODS      = 16,
  parameter int ADDR_W        = 4,
  parameter int SETTLE_CYCLES = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_MODS-1:0] bus_wdata,
  output logic [NUM_MODS-1:0] bus_rdata,
  output logic [NUM_MODS-1:0] mod_clk_en
);

  localparam int POLL_BOUND = 1000;

  initial begin
    assert (NUM_MODS == 8 || NUM_MODS == 16 || NUM_MODS == 32)
      else $error("NUM_MODS must be 8, 16 or 32");
    assert (SETTLE_CYCLES >= 1 && SETTLE_CYCLES <= POLL_BOUND / 4)
      else $error("SETTLE_CYCLES must stay well below the poll bound");
  end

  logic [NUM_MODS-1:0] stop_q;
  logic [NUM_MODS-1:0] chg_mask;
  logic [NUM_MODS-1:0] stat_q;
  reg_sel_e            reg_sel;

  mcs_regif #(.NUM_MODS(NUM_MODS), .ADDR_W(ADDR_W)) regif_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .stop_q   (stop_q),
    .chg_mask (chg_mask),
    .reg_sel  (reg_sel)
  );

  for (genvar g = 0; g < NUM_MODS; g++) begin : g_bit
    mcs_settle_bit #(.SETTLE_CYCLES(SETTLE_CYCLES)) settle_i (
      .clk   (clk),
      .rst_n (rst_n),
      .stop_i(stop_q[g]),
      .chg_i (chg_mask[g]),
      .stat_o(stat_q[g])
    );
  end

  function automatic logic [NUM_MODS-1:0] read_mux(input reg_sel_e s,
                                                   input logic [NUM_MODS-1:0] stp,
                                                   input logic [NUM_MODS-1:0] sts);
    case (s)
      SEL_STOP: return stp;
      SEL_STAT: return sts;
      default:  return '0;
    endcase
  endfunction

  assign bus_rdata  = read_mux(reg_sel, stop_q, stat_q);
  assign mod_clk_en = ~stop_q;

  AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && reg_sel == SEL_STOP) |=> (mod_clk_en == ~$past(bus_wdata))); // R1
  AST_STATUS_LAGS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_mask != '0) |=> ((stat_q & $past(chg_mask)) == ($past(stat_q) & $past(chg_mask)))); // R3
  AST_STATUS_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && reg_sel != SEL_STOP) |=> $stable(mod_clk_en)); // R7

endmodule

// File: tb/mod_clk_stop_ctrl_tb.sv
module mod_clk_stop_ctrl_tb_top;

  localparam int W  = 16;
  localparam int AW = 4;
  localparam int S  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  mod_clk_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mod_clk_stop_ctrl #(.NUM_MODS(W), .ADDR_W(AW), .SETTLE_CYCLES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en)
  );

  // Stop-register values walked by the loop; status must end equal to each.
  localparam logic [W-1:0] VEC [8] = '{
    16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A,
    16'h00FF, 16'hFF00, 16'h8001, 16'h7FFE
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the falling edge right after the write edge.
  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] prev;
    do_reset();

    // R2: reset state
    rd(4'h0, v); check("R2 stop after reset", v, 16'hFFFF);
    rd(4'h4, v); check("R2 status after reset", v, 16'hFFFF);
    check("R2 enables after reset", mod_clk_en, 16'h0000);

    // Table walk: R1 enable/readback, R3 exact status lag
    prev = 16'hFFFF;
    foreach (VEC[i]) begin
      wr(4'h0, VEC[i]);
      check("R1 enables follow write", mod_clk_en, ~VEC[i]);
      rd(4'h0, v); check("R1 stop readback", v, VEC[i]);
      tick(S - 1);
      rd(4'h4, v); check("R3 status before settle", v, prev);
      tick(1);
      rd(4'h4, v); check("R3 status after settle", v, VEC[i]);
      prev = VEC[i];
    end

    // R4: clearing then setting bit 0
    do_reset();
    wr(4'h0, 16'hFFFE);
    check("R1 bit0 enable on", mod_clk_en, 16'h0001);
    tick(S - 1);
    rd(4'h4, v); check("R3 cleared bit still 1", v, 16'hFFFF);
    tick(1);
    rd(4'h4, v); check("R3 cleared bit reads 0", v, 16'hFFFE);
    wr(4'h0, 16'hFFFF);
    check("R4 enable drops next cycle", mod_clk_en, 16'h0000);
    tick(S - 1);
    rd(4'h4, v); check("R4 status still 0 while settling", v, 16'hFFFE);
    tick(1);
    rd(4'h4, v); check("R4 status reads 1 after settle", v, 16'hFFFF);

    // R5: independent bits; rewrite of bit0 with same value keeps its count
    wr(4'h0, 16'hFFFE);           // edge k
    tick(4);                      // after k+4
    wr(4'h0, 16'hFFFC);           // edge k+5
    tick(S - 1 - 5);              // after k+S-1
    rd(4'h4, v); check("R5 no bit settled yet", v, 16'hFFFF);
    tick(1);                      // after k+S
    rd(4'h4, v); check("R5 bit0 settles on its own time", v, 16'hFFFE);
    tick(4);                      // after k+S+4
    rd(4'h4, v); check("R5 bit1 still pending", v, 16'hFFFE);
    tick(1);                      // after k+S+5
    rd(4'h4, v); check("R5 bit1 settles", v, 16'hFFFC);

    // R6: cancelled change never reaches status, later one restarts
    wr(4'h0, 16'hFFFF);
    tick(S + 2);
    wr(4'h0, 16'hFFF7);           // edge m
    tick(3);
    wr(4'h0, 16'hFFFF);           // edge m+4, back to status value
    tick(S);
    rd(4'h4, v); check("R6 cancelled change invisible", v, 16'hFFFF);
    tick(S);
    rd(4'h4, v); check("R6 still unchanged", v, 16'hFFFF);
    wr(4'h0, 16'hFFF7);
    tick(S - 1);
    rd(4'h4, v); check("R6 restart needs full delay", v, 16'hFFFF);
    tick(1);
    rd(4'h4, v); check("R6 restart settles", v, 16'hFFF7);

    // R7: writes to status and unmapped offsets ignored
    wr(4'h4, 16'h0000);
    rd(4'h0, v); check("R7 status write keeps stop", v, 16'hFFF7);
    check("R7 status write keeps enables", mod_clk_en, 16'h0008);
    tick(S + 2);
    rd(4'h4, v); check("R7 status write keeps status", v, 16'hFFF7);
    wr(4'h8, 16'h1234);
    rd(4'h0, v); check("R7 unmapped write keeps stop", v, 16'hFFF7);
    check("R7 unmapped write keeps enables", mod_clk_en, 16'h0008);
    tick(S + 2);
    rd(4'h4, v); check("R7 unmapped write keeps status", v, 16'hFFF7);
    rd(4'h8, v); check("R7 unmapped read is zero", v, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule